// File: doc/BRIEF.md
# Single-Accumulator Processor with Index Registers

This block is a small multi-cycle processor built around one 18-bit accumulator and a 1-bit carry flag. It reads instructions and operands from an external synchronous single-port memory. Each memory access goes out through a 13-bit address register and an 18-bit write-data register. A 3-bit opcode sits in the top of each word. Opcodes 0 to 6 reference memory through one of four address modes: plain, one level of indirection, offset by index register IA, or offset by index register IB. Opcode 7 treats the low bits as a sub-operation that needs no memory access.

An 18-bit input port feeds the accumulator and an 18-bit output register is loaded from it. There is a minimal subroutine call. There is a single-level interrupt that saves the return point in memory word 0 and vectors to word 1. A halt state stops the machine until reset. The ALU has two 18-bit operand inputs and a 19-bit result. Bit 18 of the result is what the carry flag takes from additions, increments and shifts.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0x0010, clears the accumulator, carry, index registers and output register, and disables interrupts. One clock after reset is released, `mem_addr` shows 0x0010 with `mem_we` low and `halted` low.
- R2: Instruction word layout is bits [17:15] opcode, [14:13] mode, [12:0] address field. Opcode 0 loads the accumulator from the effective address. Opcode 1 writes the accumulator there. Each write holds `mem_we` high for exactly one cycle.
- R3: Opcode 2 adds the memory word to the accumulator, and the unsigned carry-out goes to the carry flag. Opcode 3 is bitwise AND and opcode 4 is bitwise OR, and both leave the carry unchanged.
- R4: Mode 01 reads the word at the address field and uses its low 13 bits as the effective address.
- R5: Mode 10 adds IA and mode 11 adds IB to the address field, modulo 2^13.
- R6: Opcode 5 continues execution at the effective address.
- R7: Opcode 6 writes the address of the next instruction into the effective address and continues at the effective address plus 1. An indirect opcode 5 through that word returns.
- R8: Opcode 7 with bits [12:5] zero selects a sub-operation from bits [4:0]. The codes are 0 clear accumulator, 1 clear carry, 2 complement accumulator, and 3 increment accumulator with carry-out to the carry flag.
- R9: Sub-operation 4 shifts the accumulator left and sub-operation 5 shifts it right. Both shift in a zero and put the bit shifted out into the carry flag.
- R10: Sub-operations 6, 7 and 8 skip the next instruction when, respectively, the accumulator is zero, accumulator bit 17 is set, or the carry is set. Otherwise execution falls through.
- R11: Sub-operations 9 and 10 load IA and IB from the accumulator's low 13 bits. Sub-operations 11 and 12 copy IA and IB, zero-extended, into the accumulator. 13 loads the accumulator from `in_data`. 14 loads the output register from the accumulator.
- R12: At an instruction boundary where interrupts are enabled and `irq` is high, the processor writes the next instruction's address into word 0, disables interrupts and continues at word 1. Sub-operation 16 disables interrupts.
- R13: Sub-operation 15 enables interrupts only after the instruction that follows it has been fetched. This lets a handler end with enable followed by an indirect jump through word 0.
- R14: Sub-operation 17 halts the processor. `halted` then stays high and no memory write occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 13 | Memory address, registered |
| mem_wdata | output | 18 | Memory write data, registered |
| mem_we | output | 1 | Memory write enable, registered |
| mem_rdata | input | 18 | Memory read data, valid one cycle after the address |
| in_data | input | 18 | Input port read by the input sub-operation |
| out_data | output | 18 | Output register loaded from the accumulator |
| irq | input | 1 | Level-sensitive interrupt request |
| halted | output | 1 | High while the processor is halted |

## Verification
The checker watches properties that hold on every cycle. A halt persists and blocks writes. Write strobes appear only in the cycles that complete a store, a call or an interrupt entry. The accumulator and carry change only in the two execute states. Arithmetic results, the address modes, skip decisions, subroutine linkage and the exact boundary at which a pending interrupt is accepted after re-enabling can only be shown by the bench's programs. The bench runs short programs and compares memory contents and the output port against values worked out by hand.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    ST_FETCH, ST_FWAIT, ST_DECODE, ST_IWAIT, ST_IND,
    ST_OWAIT, ST_EXEC, ST_EXEC7, ST_INTR, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_PASSB, ALU_ADD, ALU_AND, ALU_OR, ALU_NOTA, ALU_INCA, ALU_SHL, ALU_SHR
  } alu_op_e;

  typedef enum logic [4:0] {
    SUB_CLA  = 5'd0,  SUB_CLC  = 5'd1,  SUB_CMA  = 5'd2,  SUB_INC  = 5'd3,
    SUB_SHL  = 5'd4,  SUB_SHR  = 5'd5,  SUB_SZA  = 5'd6,  SUB_SNA  = 5'd7,
    SUB_SCS  = 5'd8,  SUB_LDIA = 5'd9,  SUB_LDIB = 5'd10, SUB_STIA = 5'd11,
    SUB_STIB = 5'd12, SUB_IN   = 5'd13, SUB_OUT  = 5'd14, SUB_ION  = 5'd15,
    SUB_IOF  = 5'd16, SUB_HLT  = 5'd17
  } sub_e;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ADD   = 3'd2;
  localparam logic [2:0] OP_AND   = 3'd3;
  localparam logic [2:0] OP_OR    = 3'd4;
  localparam logic [2:0] OP_JUMP  = 3'd5;
  localparam logic [2:0] OP_CALL  = 3'd6;
  localparam logic [2:0] OP_SYS   = 3'd7;

  localparam logic [1:0] MODE_DIR = 2'b00;
  localparam logic [1:0] MODE_IND = 2'b01;
  localparam logic [1:0] MODE_IXA = 2'b10;
  localparam logic [1:0] MODE_IXB = 2'b11;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW:0]   y
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = {1'b0, a} + {1'b0, b};
      ALU_AND:  y = {1'b0, a & b};
      ALU_OR:   y = {1'b0, a | b};
      ALU_NOTA: y = {1'b0, ~a};
      ALU_INCA: y = {1'b0, a} + (DW+1)'(1);
      ALU_SHL:  y = {a, 1'b0};
      ALU_SHR:  y = {a[0], 1'b0, a[DW-1:1]};
      default:  y = {1'b0, b};
    endcase
  end
endmodule

// File: rtl/acc_agen.sv
module acc_agen
  import acc_cpu_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0] field,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] ia,
  input  logic [AW-1:0] ib,
  output logic [AW-1:0] ea,
  output logic          indirect
);
  logic [AW-1:0] offset;

  always_comb begin
    unique case (mode)
      MODE_IXA: offset = ia;
      MODE_IXB: offset = ib;
      default:  offset = '0;
    endcase
    ea       = field + offset;
    indirect = (mode == MODE_IND);
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW        = 18,
  parameter int AW        = 13,
  parameter int RESET_PC  = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  input  logic          irq,
  output logic          halted
);
  localparam int OPL = DW - 3;
  localparam int SUBW = 5;
  localparam int PADW = DW - AW;

  state_e        st;
  logic [DW-1:0] pc_q, ac_q, md_q, out_q;
  logic [AW-1:0] ma_q, ia_q, ib_q;
  logic          cf_q, ien_q, arm_q, we_q;
  logic [2:0]    ir_op;
  sub_e          ir_sub;
  logic          ir_subok;

  logic [AW-1:0] ea;
  logic          ea_ind;
  alu_op_e       alu_op;
  logic [DW:0]   alu_y;

  acc_agen #(.AW(AW)) u_agen (
    .field(mem_rdata[AW-1:0]), .mode(mem_rdata[AW+1:AW]),
    .ia(ia_q), .ib(ib_q), .ea(ea), .indirect(ea_ind)
  );

  acc_alu #(.DW(DW)) u_alu (
    .a(ac_q), .b(mem_rdata), .op(alu_op), .y(alu_y)
  );

  always_comb begin
    alu_op = ALU_PASSB;
    if (st == ST_EXEC) begin
      unique case (ir_op)
        OP_ADD:  alu_op = ALU_ADD;
        OP_AND:  alu_op = ALU_AND;
        OP_OR:   alu_op = ALU_OR;
        default: alu_op = ALU_PASSB;
      endcase
    end else begin
      unique case (ir_sub)
        SUB_CMA: alu_op = ALU_NOTA;
        SUB_INC: alu_op = ALU_INCA;
        SUB_SHL: alu_op = ALU_SHL;
        SUB_SHR: alu_op = ALU_SHR;
        default: alu_op = ALU_PASSB;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_FETCH;
      pc_q     <= DW'(RESET_PC);
      ac_q     <= '0;
      md_q     <= '0;
      out_q    <= '0;
      ma_q     <= '0;
      ia_q     <= '0;
      ib_q     <= '0;
      cf_q     <= 1'b0;
      ien_q    <= 1'b0;
      arm_q    <= 1'b0;
      we_q     <= 1'b0;
      ir_op    <= '0;
      ir_sub   <= SUB_CLA;
      ir_subok <= 1'b0;
    end else begin
      we_q <= 1'b0;
      unique case (st)
        ST_FETCH: begin
          if (ien_q && irq) begin
            ma_q  <= AW'(SAVE_ADDR);
            md_q  <= pc_q;
            we_q  <= 1'b1;
            ien_q <= 1'b0;
            st    <= ST_INTR;
          end else begin
            ma_q <= pc_q[AW-1:0];
            if (arm_q) begin
              ien_q <= 1'b1;
              arm_q <= 1'b0;
            end
            st <= ST_FWAIT;
          end
        end
        ST_FWAIT: st <= ST_DECODE;
        ST_DECODE: begin
          ir_op    <= mem_rdata[DW-1:OPL];
          ir_sub   <= sub_e'(mem_rdata[SUBW-1:0]);
          ir_subok <= (mem_rdata[AW-1:SUBW] == '0);
          pc_q     <= pc_q + DW'(1);
          if (mem_rdata[DW-1:OPL] == OP_SYS) begin
            st <= ST_EXEC7;
          end else begin
            ma_q <= ea;
            st   <= ea_ind ? ST_IWAIT : ST_OWAIT;
          end
        end
        ST_IWAIT: st <= ST_IND;
        ST_IND: begin
          ma_q <= mem_rdata[AW-1:0];
          st   <= ST_OWAIT;
        end
        ST_OWAIT: begin
          st <= ST_FETCH;
          unique case (ir_op)
            OP_STORE: begin
              md_q <= ac_q;
              we_q <= 1'b1;
            end
            OP_JUMP: pc_q <= {{PADW{1'b0}}, ma_q};
            OP_CALL: begin
              md_q <= pc_q;
              we_q <= 1'b1;
              pc_q <= {{PADW{1'b0}}, ma_q} + DW'(1);
            end
            default: st <= ST_EXEC;
          endcase
        end
        ST_EXEC: begin
          ac_q <= alu_y[DW-1:0];
          if (ir_op == OP_ADD) cf_q <= alu_y[DW];
          st <= ST_FETCH;
        end
        ST_EXEC7: begin
          st <= ST_FETCH;
          if (ir_subok) begin
            unique case (ir_sub)
              SUB_CLA:  ac_q <= '0;
              SUB_CLC:  cf_q <= 1'b0;
              SUB_CMA:  ac_q <= alu_y[DW-1:0];
              SUB_INC, SUB_SHL, SUB_SHR: begin
                ac_q <= alu_y[DW-1:0];
                cf_q <= alu_y[DW];
              end
              SUB_SZA:  if (ac_q == '0) pc_q <= pc_q + DW'(1);
              SUB_SNA:  if (ac_q[DW-1]) pc_q <= pc_q + DW'(1);
              SUB_SCS:  if (cf_q) pc_q <= pc_q + DW'(1);
              SUB_LDIA: ia_q <= ac_q[AW-1:0];
              SUB_LDIB: ib_q <= ac_q[AW-1:0];
              SUB_STIA: ac_q <= {{PADW{1'b0}}, ia_q};
              SUB_STIB: ac_q <= {{PADW{1'b0}}, ib_q};
              SUB_IN:   ac_q <= in_data;
              SUB_OUT:  out_q <= ac_q;
              SUB_ION:  arm_q <= 1'b1;
              SUB_IOF: begin
                ien_q <= 1'b0;
                arm_q <= 1'b0;
              end
              SUB_HLT:  st <= ST_HALT;
              default: ;
            endcase
          end
        end
        ST_INTR: begin
          pc_q <= DW'(VEC_ADDR);
          st   <= ST_FETCH;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assign mem_addr  = ma_q;
  assign mem_wdata = md_q;
  assign mem_we    = we_q;
  assign out_data  = out_q;
  assign halted    = (st == ST_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic          halted,
  input state_e        st,
  input logic [DW-1:0] ac,
  input logic          cf
);
  // R14: a halt persists until reset
  a_r14_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R14: no memory write while halted
  a_r14_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R2: write strobes only in the cycle after a store/call completes or in interrupt entry
  a_r2_write_slot: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (st == ST_FETCH || st == ST_INTR));

  // R3: the carry flag moves only out of an execute state
  a_r3_cf_exec_only: assert property (@(posedge clk) disable iff (rst)
    (st != ST_EXEC && st != ST_EXEC7) |=> $stable(cf));

  // R8: the accumulator moves only out of an execute state
  a_r8_ac_exec_only: assert property (@(posedge clk) disable iff (rst)
    (st != ST_EXEC && st != ST_EXEC7) |=> $stable(ac));

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .halted(halted),
  .st(st), .ac(ac_q), .cf(cf_q)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 512;

  typedef struct packed {
    logic [17:0] ins;
    logic [17:0] a;
    logic [17:0] b;
    logic [17:0] y;
    logic        c;
  } vec_t;

  // ins at 0x11; a loaded from 0x100; b at 0x101; expected accumulator and carry
  localparam vec_t VEC [12] = '{
    '{18'h10101, 18'h00005, 18'h00007, 18'h0000C, 1'b0}, // R3 add
    '{18'h10101, 18'h3FFFF, 18'h00001, 18'h00000, 1'b1}, // R3 add wrap
    '{18'h10101, 18'h20000, 18'h20000, 18'h00000, 1'b1}, // R3 add top bits
    '{18'h18101, 18'h3F0F0, 18'h0FF0F, 18'h0F000, 1'b0}, // R3 and
    '{18'h20101, 18'h00F00, 18'h000F1, 18'h00FF1, 1'b0}, // R3 or
    '{18'h00101, 18'h11111, 18'h2ABCD, 18'h2ABCD, 1'b0}, // R2 load
    '{18'h38002, 18'h0F0F0, 18'h00000, 18'h30F0F, 1'b0}, // R8 complement
    '{18'h38003, 18'h3FFFF, 18'h00000, 18'h00000, 1'b1}, // R8 increment
    '{18'h38004, 18'h20001, 18'h00000, 18'h00002, 1'b1}, // R9 left
    '{18'h38005, 18'h00003, 18'h00000, 18'h00001, 1'b1}, // R9 right
    '{18'h38005, 18'h00002, 18'h00000, 18'h00001, 1'b0}, // R9 right no carry
    '{18'h38000, 18'h12345, 18'h00000, 18'h00000, 1'b0}  // R8 clear
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] mem_addr;
  logic [17:0] mem_wdata;
  logic        mem_we;
  logic [17:0] mem_rdata = '0;
  logic [17:0] in_data = '0;
  logic [17:0] out_data;
  logic        irq = 1'b0;
  logic        halted;

  logic [17:0] mem [MEMW];
  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  int vec_wr = 0;
  int cycles = 0;

  acc_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .out_data(out_data), .irq(irq), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[8:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (mem_addr == 13'h0) vec_wr <= vec_wr + 1;
    end
    mem_rdata <= mem[mem_addr[8:0]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_halt();
    for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
  endtask

  initial begin
    // R1 reset state and first fetch address
    clear_mem();
    mem[16] = 18'h38011;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_data", out_data, 18'h0);
    chk("R1 halted", {17'h0, halted}, 18'h0);
    chk("R1 mem_we", {17'h0, mem_we}, 18'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first fetch addr", {5'h0, mem_addr}, 18'h00010);

    // table of arithmetic and accumulator operations
    for (int v = 0; v < 12; v++) begin
      clear_mem();
      mem[9'h10] = 18'h00100;  // load 0x100
      mem[9'h11] = VEC[v].ins;
      mem[9'h12] = 18'h08102;  // store 0x102
      mem[9'h13] = 18'h38008;  // skip if carry
      mem[9'h14] = 18'h38011;  // halt
      mem[9'h15] = 18'h38000;  // clear
      mem[9'h16] = 18'h38002;  // complement
      mem[9'h17] = 18'h08103;  // store 0x103
      mem[9'h18] = 18'h38011;
      mem[9'h100] = VEC[v].a;
      mem[9'h101] = VEC[v].b;
      start();
      run_halt();
      chk($sformatf("R2 R3 R8 R9 result vec%0d", v), mem[9'h102], VEC[v].y);
      chk($sformatf("R10 carry vec%0d", v), mem[9'h103], VEC[v].c ? 18'h3FFFF : 18'h0);
    end

    // R5 index IA with wraparound: 0x1F00 + 0x150 -> 0x0050
    clear_mem();
    mem[9'h10] = 18'h00100;
    mem[9'h11] = 18'h38009;  // IA <- acc
    mem[9'h12] = 18'h05F00;  // load IA-indexed 0x1F00
    mem[9'h13] = 18'h3800E;  // out
    mem[9'h14] = 18'h38011;
    mem[9'h100] = 18'h00150;
    mem[9'h50] = 18'h01234;
    start();
    run_halt();
    chk("R5 IA wrap", out_data, 18'h01234);

    // R5 IB, R11 copy IB back, R4 indirect
    clear_mem();
    mem[9'h10] = 18'h00100;
    mem[9'h11] = 18'h3800A;  // IB <- acc
    mem[9'h12] = 18'h38000;
    mem[9'h13] = 18'h3800C;  // acc <- IB
    mem[9'h14] = 18'h16101;  // add IB-indexed 0x101
    mem[9'h15] = 18'h08107;
    mem[9'h16] = 18'h02105;  // load indirect via 0x105
    mem[9'h17] = 18'h3800E;
    mem[9'h18] = 18'h38011;
    mem[9'h100] = 18'h00003;
    mem[9'h101] = 18'h00005;
    mem[9'h104] = 18'h0000A;
    mem[9'h105] = 18'h00106;
    mem[9'h106] = 18'h00777;
    start();
    run_halt();
    chk("R5 R11 IB add", mem[9'h107], 18'h0000D);
    chk("R4 indirect", out_data, 18'h00777);
    chk("R14 halted", {17'h0, halted}, 18'h1);

    // R6 jump
    clear_mem();
    mem[9'h10] = 18'h28020;
    mem[9'h11] = 18'h38011;
    mem[9'h20] = 18'h00100;
    mem[9'h21] = 18'h3800E;
    mem[9'h22] = 18'h38011;
    mem[9'h100] = 18'h00055;
    start();
    run_halt();
    chk("R6 jump", out_data, 18'h00055);

    // R7 call and indirect return
    clear_mem();
    mem[9'h10] = 18'h30030;  // call 0x30
    mem[9'h11] = 18'h3800E;
    mem[9'h12] = 18'h38011;
    mem[9'h31] = 18'h00100;
    mem[9'h32] = 18'h2A030;  // jump indirect 0x30
    mem[9'h100] = 18'h00066;
    start();
    run_halt();
    chk("R7 link word", mem[9'h30], 18'h00011);
    chk("R7 return", out_data, 18'h00066);

    // R10 skips taken and not taken
    clear_mem();
    mem[9'h10] = 18'h38000;
    mem[9'h11] = 18'h38006;
    mem[9'h12] = 18'h38011;
    mem[9'h13] = 18'h38002;
    mem[9'h14] = 18'h38007;
    mem[9'h15] = 18'h38011;
    mem[9'h16] = 18'h38006;
    mem[9'h17] = 18'h3800E;
    mem[9'h18] = 18'h38011;
    start();
    run_halt();
    chk("R10 skips", out_data, 18'h3FFFF);

    // R11 input, R14 no writes after halt
    clear_mem();
    mem[9'h10] = 18'h3800D;
    mem[9'h11] = 18'h08100;
    mem[9'h12] = 18'h38011;
    in_data = 18'h02468;
    start();
    run_halt();
    chk("R11 input", mem[9'h100], 18'h02468);
    begin
      int w0;
      w0 = wr_cnt;
      repeat (20) @(negedge clk);
      chk("R14 no writes halted", 18'(wr_cnt - w0), 18'h0);
      chk("R14 still halted", {17'h0, halted}, 18'h1);
    end

    // R12 R13 interrupt entry, enable delay, re-entry
    clear_mem();
    mem[9'h01] = 18'h3800E;  // out
    mem[9'h02] = 18'h3800F;  // enable
    mem[9'h03] = 18'h2A000;  // jump indirect 0
    mem[9'h10] = 18'h3800F;  // enable
    mem[9'h11] = 18'h38003;  // increment
    mem[9'h12] = 18'h28011;  // jump 0x11
    irq = 1'b1;
    vec_wr = 0;
    start();
    for (int i = 0; i < 200 && !(mem_we && mem_addr == 13'h0); i++) @(negedge clk);
    irq = 1'b0;
    repeat (40) @(negedge clk);
    chk("R13 save after delay", mem[9'h0], 18'h00012);
    chk("R12 handler ran", out_data, 18'h00001);
    chk("R12 single entry", 18'(vec_wr), 18'h1);
    irq = 1'b1;
    for (int i = 0; i < 200 && !(mem_we && mem_addr == 13'h0); i++) @(negedge clk);
    irq = 1'b0;
    repeat (40) @(negedge clk);
    chk("R12 reentry", 18'(vec_wr), 18'h2);
    chk("R12 second out", {17'h0, (out_data > 18'h1)}, 18'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule